// File: doc/BRIEF.md
# Virtual Register Slot Table

The block keeps a small set of virtual register slots. Each slot that is in use holds a one-hot row over the real register file. The set bit names the real register that an in-flight instruction is working on. Downstream dependency matrices can then be indexed by slot rather than by real register, so a single select line fans out to a few slots instead of to every real register.

Issue logic presents a real register on the claim port and receives, in the same cycle, a grant and the index of the slot it was given. The lowest-numbered free slot is always chosen. When the instruction completes, retirement logic frees that slot through the release port. A lookup port takes a real register number and reports, combinationally, whether any occupied slot maps it and which slot that is. When every slot is occupied and nothing is released in that cycle, the table raises stall and refuses the claim. A release in the same cycle opens its slot for immediate reuse.

Top module: `vrm_table`

## Requirements
- R1: After reset every slot is free, stall is low and a lookup of any real register misses.
- R2: A claim (claimValid high, stall low) is granted in the same cycle, and claimSlot is the lowest-indexed slot that is free at that moment. A slot being released in that cycle does not count as free unless the table is full.
- R3: From the cycle after a granted claim, a lookup of the claimed real register hits and returns the claimed slot.
- R4: A release of an occupied slot frees it from the next cycle on. Lookups no longer see its register through that slot, and the slot can be claimed again. A release must name an occupied slot.
- R5: When all slots are occupied and no release is presented, stall is high and a claim gets no grant and leaves the table unchanged.
- R6: When all slots are occupied and a release is presented, stall is low, and a claim in that cycle is granted the slot being released.
- R7: When several occupied slots map the same real register, the lookup returns the lowest-indexed of them.
- R8: Each slot row has at most one bit set. A lookup hits only on registers that a live claim mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| claimValid | input | 1 | Request for a slot |
| claimReg | input | $clog2(NUM_REGS) | Real register to map into the claimed slot |
| claimGrant | output | 1 | Claim accepted this cycle |
| claimSlot | output | $clog2(NUM_SLOTS) | Slot given to the claim |
| releaseValid | input | 1 | Free a slot at the next edge |
| releaseSlot | input | $clog2(NUM_SLOTS) | Slot to free |
| lookupReg | input | $clog2(NUM_REGS) | Real register to search for |
| lookupHit | output | 1 | Some occupied slot maps lookupReg |
| lookupSlot | output | $clog2(NUM_SLOTS) | Lowest such slot |
| stall | output | 1 | Table full and no release this cycle |

## Verification
Grant, slot index and stall depend only on the current inputs and the registered occupancy. They are due in the same cycle as the claim and release inputs, and the bench samples them one time step after driving the inputs at the falling edge. The table contents change at the next rising edge. Each effect of a claim or release on lookup is therefore checked from the following falling edge onward, by sweeping all 128 real registers against an occupancy model that the bench keeps itself.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  // Strobes from control to row storage
  typedef struct packed {
    logic load;   // write a one-hot row into loadSlot
    logic clear;  // zero the row at clearSlot
  } vrmStrobeT;
endpackage

// File: rtl/vrm_ctrl.sv
module vrm_ctrl
  import vrm_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              claimValid,
  input  logic              releaseValid,
  input  logic [SLOT_W-1:0] releaseSlot,
  output logic              claimGrant,
  output logic [SLOT_W-1:0] claimSlot,
  output logic              stall,
  output vrmStrobeT         strobe,
  output logic [SLOT_W-1:0] loadSlot,
  output logic [SLOT_W-1:0] clearSlot
);
  logic [NUM_SLOTS-1:0] busyQ, busyD;
  logic [SLOT_W-1:0]    lowFree;
  logic                 full;

  assign full = &busyQ;

  // priority encoder: lowest free slot wins
  always_comb begin
    lowFree = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busyQ[i]) lowFree = SLOT_W'(i);
    end
  end

  assign stall      = full && !releaseValid;
  assign claimSlot  = full ? releaseSlot : lowFree;
  assign claimGrant = claimValid && !stall;

  assign strobe.load  = claimGrant;
  assign strobe.clear = releaseValid;
  assign loadSlot     = claimSlot;
  assign clearSlot    = releaseSlot;

  always_comb begin
    busyD = busyQ;
    if (releaseValid) busyD[releaseSlot] = 1'b0;
    if (claimGrant)   busyD[claimSlot]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyD;
  end

  // R4
  release_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> busyQ[releaseSlot]);
  // R5
  no_grant_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !claimGrant);
  // R2
  grant_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimGrant && !full) |-> !busyQ[claimSlot]);
  // R6
  full_reuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimGrant && full) |-> (releaseValid && claimSlot == releaseSlot));
  // R3
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    claimGrant |=> busyQ[$past(claimSlot)]);
endmodule

// File: rtl/vrm_data.sv
module vrm_data
  import vrm_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_REGS  = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vrmStrobeT         strobe,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [REG_W-1:0]  loadReg,
  input  logic [SLOT_W-1:0] clearSlot,
  input  logic [REG_W-1:0]  lookupReg,
  output logic              lookupHit,
  output logic [SLOT_W-1:0] lookupSlot
);
  logic [NUM_REGS-1:0]  rowQ [NUM_SLOTS];
  logic [NUM_REGS-1:0]  loadRow;
  logic [NUM_SLOTS-1:0] colHit;

  always_comb begin
    loadRow = '0;
    loadRow[loadReg] = 1'b1;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gRow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rowQ[s] <= '0;
      end else if (strobe.load && loadSlot == SLOT_W'(s)) begin
        rowQ[s] <= loadRow;
      end else if (strobe.clear && clearSlot == SLOT_W'(s)) begin
        rowQ[s] <= '0;
      end
    end
    assign colHit[s] = rowQ[s][lookupReg];

    // R8
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(rowQ[s]));
    // R3
    row_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && loadSlot == SLOT_W'(s)) |=> rowQ[s][$past(loadReg)]);
  end

  assign lookupHit = |colHit;

  always_comb begin
    lookupSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (colHit[i]) lookupSlot = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/vrm_table.sv
module vrm_table
  import vrm_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_REGS  = 128,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int REG_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              claimValid,
  input  logic [REG_W-1:0]  claimReg,
  output logic              claimGrant,
  output logic [SLOT_W-1:0] claimSlot,
  input  logic              releaseValid,
  input  logic [SLOT_W-1:0] releaseSlot,
  input  logic [REG_W-1:0]  lookupReg,
  output logic              lookupHit,
  output logic [SLOT_W-1:0] lookupSlot,
  output logic              stall
);
  vrmStrobeT         strobe;
  logic [SLOT_W-1:0] loadSlot, clearSlot;

  vrm_ctrl #(.NUM_SLOTS(NUM_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .claimValid(claimValid), .releaseValid(releaseValid), .releaseSlot(releaseSlot),
    .claimGrant(claimGrant), .claimSlot(claimSlot), .stall(stall),
    .strobe(strobe), .loadSlot(loadSlot), .clearSlot(clearSlot)
  );

  vrm_data #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .loadSlot(loadSlot), .loadReg(claimReg), .clearSlot(clearSlot),
    .lookupReg(lookupReg), .lookupHit(lookupHit), .lookupSlot(lookupSlot)
  );
endmodule

// File: tb/vrm_table_test.sv
module vrm_table_test;
  localparam int PERIOD = 10;
  localparam int NS = 8;
  localparam int NR = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       claimValid = 1'b0;
  logic [6:0] claimReg = '0;
  logic       claimGrant;
  logic [2:0] claimSlot;
  logic       releaseValid = 1'b0;
  logic [2:0] releaseSlot = '0;
  logic [6:0] lookupReg = '0;
  logic       lookupHit;
  logic [2:0] lookupSlot;
  logic       stall;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mBusy [NS];
  int mReg  [NS];

  always #(PERIOD/2) clk = ~clk;

  vrm_table uut (
    .clk(clk), .rstN(rstN),
    .claimValid(claimValid), .claimReg(claimReg),
    .claimGrant(claimGrant), .claimSlot(claimSlot),
    .releaseValid(releaseValid), .releaseSlot(releaseSlot),
    .lookupReg(lookupReg), .lookupHit(lookupHit), .lookupSlot(lookupSlot),
    .stall(stall)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every real register lookup against the model
  task automatic sweep(input string req);
    for (int r = 0; r < NR; r++) begin
      int expSlot = -1;
      lookupReg = 7'(r);
      #1;
      for (int s = NS - 1; s >= 0; s--) if (mBusy[s] && mReg[s] == r) expSlot = s;
      check(req, $sformatf("hit reg %0d", r), int'(lookupHit), int'(expSlot >= 0));
      if (expSlot >= 0) check(req, $sformatf("slot reg %0d", r), int'(lookupSlot), expSlot);
    end
  endtask

  // one cycle of claim/release with same-cycle expectations, then model update
  task automatic step(input string req, input bit cv, input int cr, input bit rv, input int rs);
    bit full = 1;
    bit expStall;
    bit expGrant;
    int expSlot = 0;
    @(negedge clk);
    claimValid = cv; claimReg = 7'(cr); releaseValid = rv; releaseSlot = 3'(rs);
    #1;
    for (int s = 0; s < NS; s++) if (!mBusy[s]) full = 0;
    for (int s = NS - 1; s >= 0; s--) if (!mBusy[s]) expSlot = s;
    if (full) expSlot = rs;
    expStall = full && !rv;
    expGrant = cv && !expStall;
    check(req, "stall", int'(stall), int'(expStall));
    check(req, "grant", int'(claimGrant), int'(expGrant));
    if (expGrant) check(req, "claimSlot", int'(claimSlot), expSlot);
    @(posedge clk);
    if (rv) mBusy[rs] = 0;
    if (expGrant) begin mBusy[expSlot] = 1; mReg[expSlot] = cr; end
    @(negedge clk);
    claimValid = 0; releaseValid = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin mBusy[s] = 0; mReg[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1
    check("R1", "stall after reset", int'(stall), 0);
    sweep("R1");

    // R2 fill all slots in order, distinct registers
    for (int k = 0; k < NS; k++) step("R2", 1, 3 * k + 5, 0, 0);
    // R3 R8 every mapped register hits its slot, all others miss
    sweep("R3");

    // R5 full, claim refused, table unchanged
    step("R5", 1, 90, 0, 0);
    sweep("R5");

    // R6 full with release: released slot reused in same cycle
    step("R6", 1, 100, 1, 5);
    sweep("R6");

    // R4 release two slots, their registers disappear
    step("R4", 0, 0, 1, 2);
    step("R4", 0, 0, 1, 6);
    sweep("R4");

    // R2 lowest free chosen after releases
    step("R2", 1, 7, 0, 0);
    check("R2", "slot 2 refilled", int'(mBusy[2]), 1);

    // R2 release and claim together when not full: releasing slot not reused
    step("R2", 1, 50, 1, 3);
    sweep("R2");

    // R7 duplicate mapping of slot 0's register lands in slot 3 (lowest free)
    step("R7", 1, 5, 0, 0);
    sweep("R7");
    step("R7", 0, 0, 1, 0);
    sweep("R7");

    // R8 release everything, table empty again
    for (int s = 0; s < NS; s++) if (mBusy[s]) step("R8", 0, 0, 1, s);
    sweep("R8");
    step("R2", 1, 127, 0, 0);
    check("R2", "first slot after empty", int'(mBusy[0]), 1);
    sweep("R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule